// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the address sequence for a pipelined synchronous burst memory. On a rising clock edge it captures a starting address when one of two active-low address strobes is asserted. One strobe comes from the processor side and one from the cache-controller side. It then walks the two low address bits through a burst of four accesses. The count steps only on cycles where the active-low advance input is asserted. Otherwise the current address is held.

A static order input picks how the two low bits move. In linear order they count up from the start value and wrap modulo four. In interleaved order they are the start value XOR the burst count. The upper address bits never change inside a burst. The processor-side strobe only takes effect while the active-low pipelining chip enable is asserted. The controller-side strobe always loads. A load takes priority over advance in the same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is 0 and `burst_pos` is 0.
- R2: `strobe_ctl_n` low at a rising edge loads `addr_in` into `addr_out` and sets `burst_pos` to 0 whatever the level of `ce_n`; the new address appears after that edge.
- R3: `strobe_cpu_n` low loads `addr_in` only when `ce_n` is low. With `ce_n` high, and `strobe_ctl_n` and `adv_n` high, `addr_out` and `burst_pos` are unchanged after the edge.
- R4: With no load and `adv_n` low at an edge, `burst_pos` increases by one modulo 4 (0,1,2,3,0).
- R5: With no load and `adv_n` high at an edge, `addr_out` and `burst_pos` are unchanged.
- R6: With `interleave` = 0 (linear), `addr_out[1:0]` equals (start[1:0] + `burst_pos`) mod 4.
- R7: With `interleave` = 1, `addr_out[1:0]` equals start[1:0] XOR `burst_pos`.
- R8: `addr_out[ADDR_W-1:2]` equals the loaded start address throughout a burst; no carry leaves the low two bits.
- R9: When both strobes and `adv_n` are low at the same edge, the load takes effect: `addr_out` becomes `addr_in` and `burst_pos` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, clears address and count |
| ce_n | input | 1 | Active-low pipelining chip enable, qualifies the processor strobe |
| strobe_cpu_n | input | 1 | Active-low processor-side address strobe |
| strobe_ctl_n | input | 1 | Active-low controller-side address strobe |
| adv_n | input | 1 | Active-low burst advance |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External starting address |
| addr_out | output | ADDR_W | Current burst address |
| burst_pos | output | 2 | Position within the burst, 0 to 3 |

## Verification
Each of the four start values of the low bits is run through a full burst plus one wrap step in both orders. Start values 0 and 2 give the same sequence in both orders, while 1 and 3 tell the orders apart. A start address with all upper bits set exposes any carry out of the low field. Directed cases pit the processor strobe against a deasserted chip enable. Other directed cases check held advance and the three-way collision of both strobes with advance.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  localparam int unsigned BURST_W = 2;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

  function automatic logic [BURST_W-1:0] linear_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] count
  );
    return start + count;
  endfunction

  function automatic logic [BURST_W-1:0] interleave_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] count
  );
    return start ^ count;
  endfunction

  function automatic logic [BURST_W-1:0] step_count(
    input logic [BURST_W-1:0] count
  );
    return count + 1'b1;
  endfunction

endpackage

// File: rtl/bseq_load_ctrl.sv
module bseq_load_ctrl (
  input  logic ce_n,
  input  logic strobe_cpu_n,
  input  logic strobe_ctl_n,
  output logic cpu_load,
  output logic ctl_load,
  output logic load
);

  always_comb begin
    cpu_load = ~strobe_cpu_n & ~ce_n;
    ctl_load = ~strobe_ctl_n;
    load     = cpu_load | ctl_load;
  end

endmodule

// File: rtl/bseq_counter.sv
module bseq_counter
  import bseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               adv_n,
  output logic [BURST_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (load)   count <= '0;
    else if (!adv_n) count <= step_count(count);
  end

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == '0); // R9
  AST_ADV_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n) |=> count == BURST_W'($past(count) + 1'b1)); // R4
  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> $stable(count)); // R5

endmodule

// File: rtl/bseq_addr_reg.sv
module bseq_addr_reg #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base <= '0;
    else if (load) base <= addr_in;
  end

  AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base)); // R8

endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import bseq_pkg::*;
(
  input  logic               interleave,
  input  logic [BURST_W-1:0] start_low,
  input  logic [BURST_W-1:0] count,
  output logic [BURST_W-1:0] cur_low
);

  logic [BURST_W-1:0] lin_low;
  logic [BURST_W-1:0] il_low;

  always_comb begin
    lin_low = linear_low(start_low, count);
    il_low  = interleave_low(start_low, count);
    cur_low = (order_e'(interleave) == ORDER_INTERLEAVE) ? il_low : lin_low;
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        burst_pos
);

  localparam int unsigned UPPER_W = ADDR_W - BURST_W;

  logic               cpu_load;
  logic               ctl_load;
  logic               load;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] count_q;
  logic [BURST_W-1:0] cur_low;

  bseq_load_ctrl u_load (
    .ce_n         (ce_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .cpu_load     (cpu_load),
    .ctl_load     (ctl_load),
    .load         (load)
  );

  bseq_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .addr_in (addr_in),
    .base    (base_q)
  );

  bseq_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .adv_n (adv_n),
    .count (count_q)
  );

  bseq_order u_order (
    .interleave (interleave),
    .start_low  (base_q[BURST_W-1:0]),
    .count      (count_q),
    .cur_low    (cur_low)
  );

  assign addr_out  = {base_q[ADDR_W-1:BURST_W], cur_low};
  assign burst_pos = count_q;

  AST_CTL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_load |=> (addr_out == $past(addr_in)) && (burst_pos == 2'd0)); // R2
  AST_CPU_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_load |=> addr_out == $past(addr_in)); // R3
  AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu_n && ce_n && strobe_ctl_n && adv_n) |=> $stable(addr_out) && $stable(burst_pos)); // R3
  AST_LINEAR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !interleave |-> 2'(addr_out[1:0] - base_q[1:0]) == burst_pos); // R6
  AST_INTERLEAVE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    interleave |-> (addr_out[1:0] ^ base_q[1:0]) == burst_pos); // R7
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_out[ADDR_W-1:BURST_W])); // R8
  AST_UPPER_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    addr_out[ADDR_W-1:BURST_W] == base_q[BURST_W +: UPPER_W]); // R8

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          strobe_cpu_n = 1'b1;
  logic          strobe_ctl_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          interleave = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    burst_pos;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .adv_n(adv_n), .interleave(interleave),
    .addr_in(addr_in), .addr_out(addr_out), .burst_pos(burst_pos)
  );

  // {order, start address, expected low bits for positions 0,1,2,3}
  localparam logic [25:0] VEC [8] = '{
    {1'b0, 17'h1A5C0, 8'b00_01_10_11},
    {1'b1, 17'h1A5C0, 8'b00_01_10_11},
    {1'b0, 17'h00F31, 8'b01_10_11_00},
    {1'b1, 17'h00F31, 8'b01_00_11_10},
    {1'b0, 17'h12342, 8'b10_11_00_01},
    {1'b1, 17'h12342, 8'b10_11_00_01},
    {1'b0, 17'h1FFFF, 8'b11_00_01_10},
    {1'b1, 17'h1FFFF, 8'b11_10_01_00}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [AW-1:0] got_a,
                       input logic [AW-1:0] exp_a, input logic [1:0] got_p,
                       input logic [1:0] exp_p);
    checks++;
    if (got_a !== exp_a || got_p !== exp_p) begin
      errors++;
      $display("FAIL %s: addr=%h pos=%0d expected addr=%h pos=%0d",
               req, got_a, got_p, exp_a, exp_p);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    logic [1:0]    e;
    #12;
    check("R1 reset", addr_out, '0, burst_pos, 2'd0);
    rst_n = 1'b1;
    tick();
    check("R1 after release", addr_out, '0, burst_pos, 2'd0);

    // table walk: R2 load, R4 advance with wrap, R6/R7 order, R8 upper bits
    for (int v = 0; v < 8; v++) begin
      interleave = VEC[v][25];
      a = VEC[v][24:8];
      addr_in = a;
      ce_n = 1'b1;
      strobe_ctl_n = 1'b0;
      adv_n = 1'b1;
      tick();
      strobe_ctl_n = 1'b0 ^ 1'b1;
      addr_in = ~a;
      e = VEC[v][7:6];
      check(interleave ? "R2 R7 load" : "R2 R6 load", addr_out, {a[AW-1:2], e}, burst_pos, 2'd0);
      adv_n = 1'b0;
      for (int k = 1; k <= 4; k++) begin
        tick();
        e = VEC[v][7 - 2*(k % 4) -: 2];
        check(interleave ? "R4 R7 R8 step" : "R4 R6 R8 step",
              addr_out, {a[AW-1:2], e}, burst_pos, 2'(k % 4));
      end
      adv_n = 1'b1;
    end

    // R5: advance held high keeps the address (linear, start 1, pos 1)
    interleave = 1'b0;
    addr_in = 17'h0B0B1;
    strobe_ctl_n = 1'b0;
    tick();
    strobe_ctl_n = 1'b1;
    adv_n = 1'b0;
    tick();
    adv_n = 1'b1;
    check("R5 pre", addr_out, 17'h0B0B2, burst_pos, 2'd1);
    tick();
    tick();
    check("R5 hold", addr_out, 17'h0B0B2, burst_pos, 2'd1);

    // R3: processor strobe ignored while chip enable is high
    ce_n = 1'b1;
    strobe_cpu_n = 1'b0;
    addr_in = 17'h15555;
    tick();
    check("R3 gated", addr_out, 17'h0B0B2, burst_pos, 2'd1);
    ce_n = 1'b0;
    tick();
    strobe_cpu_n = 1'b1;
    check("R3 enabled load", addr_out, 17'h15555, burst_pos, 2'd0);

    // R2: controller strobe loads even with chip enable high
    ce_n = 1'b1;
    adv_n = 1'b0;
    tick();
    tick();
    adv_n = 1'b1;
    check("R4 pre-collision", addr_out, 17'h15557, burst_pos, 2'd2);
    addr_in = 17'h0C3A8;
    strobe_ctl_n = 1'b0;
    tick();
    strobe_ctl_n = 1'b1;
    check("R2 ctl load ce high", addr_out, 17'h0C3A8, burst_pos, 2'd0);

    // R9: both strobes and advance together, load wins
    interleave = 1'b1;
    adv_n = 1'b0;
    tick();
    tick();
    tick();
    check("R7 pre-collision", addr_out, 17'h0C3AB, burst_pos, 2'd3);
    ce_n = 1'b0;
    strobe_cpu_n = 1'b0;
    strobe_ctl_n = 1'b0;
    addr_in = 17'h03E71;
    tick();
    strobe_cpu_n = 1'b1;
    strobe_ctl_n = 1'b1;
    adv_n = 1'b1;
    check("R9 load beats advance", addr_out, 17'h03E71, burst_pos, 2'd0);

    // R1: reset in mid-burst clears everything
    adv_n = 1'b0;
    tick();
    rst_n = 1'b0;
    #1;
    check("R1 mid-burst reset", addr_out, '0, burst_pos, 2'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule